// File: doc/BRIEF.md
# Drain-Source Monitor with Blanking

This block watches six external power switches for a drain-source voltage that stays too high while the switch should be fully conducting. For each switch, an analog comparator delivers an asynchronous flag. The gate logic supplies a per-switch indication that the gate is being driven, and it raises that indication only after the dead time has elapsed. Once the indication is high, the block waits a programmable blanking interval, so that the switching transient has settled before the flag is trusted. After that interval, a synchronized comparator flag that is high marks the switch as faulty.

Two configuration bits set the reaction to a fault. The fault can be ignored, reported only, or reported together with a latched request to switch the whole bridge off. That request stays latched until the diagnostics block returns an acknowledge pulse. A new error appearing on any switch produces a one-cycle event toward the diagnostics block.

Top module: `dsm_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `vds_err`, `err_evt` and `bridge_off` are all 0.
- R2: With the default `CLK_KHZ` of 20000, the blanking length in cycles is 136, 68, 34 and 16 for `blank_sel` codes 0, 1, 2 and 3. A switch whose flag is already settled high shows `vds_err` exactly blanking+1 cycles after its `gate_live` bit rises.
- R3: `vds_err[i]` is 1 in a cycle exactly when, at the previous edge, `gate_live[i]` had been high for at least the blanking length, the flag synchronized through two flops was high, and `chk_en` was 1. A change on `vds_hi` therefore reaches `vds_err` after three edges.
- R4: A low `gate_live[i]` clears that switch's blanking count at once. When the bit returns high, the full interval starts again from zero.
- R5: While `chk_en` is 0, `vds_err` stays 0 and no event is produced. No new bridge-off request is raised.
- R6: With `chk_en`=1 and `shut_en`=0, errors show on `vds_err` and `err_evt`, and `bridge_off` does not rise.
- R7: With `chk_en`=1 and `shut_en`=1, any error sets `bridge_off` in the same cycle it appears on `vds_err`. The bit holds until a cycle in which `dis_ack` is sampled high and no error is being raised.
- R8: `err_evt` is high for a cycle exactly when at least one `vds_err` bit went from 0 to 1 at that edge.
- R9: Each switch is qualified only by its own gate, flag and counter. A flag on one switch never marks another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_live | input | NSW | Gate driven, dead time already elapsed, one bit per switch |
| vds_hi | input | NSW | Asynchronous comparator flags: drain-source voltage above threshold |
| blank_sel | input | 2 | Blanking length code (0 longest, 3 shortest) |
| chk_en | input | 1 | Enables drain-source checking |
| shut_en | input | 1 | Turns a reported error into a bridge-off request |
| dis_ack | input | 1 | Acknowledge pulse that clears the bridge-off latch |
| vds_err | output | NSW | Per-switch error flags |
| err_evt | output | 1 | One-cycle pulse on any newly raised error |
| bridge_off | output | 1 | Latched request to disable all gate drivers |

## Verification
A blanking counter that is off by even one count moves the first `vds_err` of a switch by one cycle. A counter that keeps its value across a gate-off moves it by many cycles. Either shift shows at the port in the cycle the error should have appeared. A lost synchronizer stage shows the same way, one cycle early. A latch that clears without an acknowledge, or sets without `shut_en`, is visible on `bridge_off` in the very next cycle. For this reason the outputs are compared against a behavioural model on every clock rather than only at the end of each scenario.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic [1:0] {
        RX_IGNORE = 2'd0,
        RX_REPORT = 2'd1,
        RX_SHUT   = 2'd2
    } react_e;

    // Nominal blanking lengths in ns, scaled to cycles of a clk_khz clock.
    function automatic int blank_cycles(input logic [1:0] code, input int clk_khz);
        int ns;
        case (code)
            2'd0:    ns = 6800;
            2'd1:    ns = 3400;
            2'd2:    ns = 1700;
            default: ns = 800;
        endcase
        return (ns * clk_khz) / 1000000;
    endfunction

    function automatic react_e react_mode(input logic chk, input logic shut);
        if (!chk)
            return RX_IGNORE;
        return shut ? RX_SHUT : RX_REPORT;
    endfunction

endpackage

// File: rtl/dsm_sync.sv
module dsm_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/dsm_blank_timer.sv
module dsm_blank_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          live,
    input  logic [CW-1:0] lim,
    output logic          armed
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !live)
            cnt <= '0;
        else if (cnt < lim)
            cnt <= cnt + 1'b1;
    end

    assign armed = live && (cnt >= lim);
endmodule

// File: rtl/dsm_fault_ctl.sv
module dsm_fault_ctl
    import dsm_pkg::*;
#(
    parameter int NSW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSW-1:0] armed,
    input  logic [NSW-1:0] flag_s,
    input  logic           chk_en,
    input  logic           shut_en,
    input  logic           dis_ack,
    output logic [NSW-1:0] err,
    output logic           evt,
    output logic           off
);
    react_e         mode;
    logic [NSW-1:0] err_nx;
    logic           trip;

    always_comb begin
        mode   = react_mode(chk_en, shut_en);
        err_nx = (mode == RX_IGNORE) ? '0 : (armed & flag_s);
        trip   = (mode == RX_SHUT) && (|err_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= '0;
            evt <= 1'b0;
            off <= 1'b0;
        end else begin
            err <= err_nx;
            evt <= |(err_nx & ~err);
            off <= trip || (off && !dis_ack);
        end
    end
endmodule

// File: rtl/dsm_monitor.sv
module dsm_monitor
    import dsm_pkg::*;
#(
    parameter int NSW     = 6,
    parameter int CLK_KHZ = 20000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSW-1:0] gate_live,
    input  logic [NSW-1:0] vds_hi,
    input  logic [1:0]     blank_sel,
    input  logic           chk_en,
    input  logic           shut_en,
    input  logic           dis_ack,
    output logic [NSW-1:0] vds_err,
    output logic           err_evt,
    output logic           bridge_off
);
    localparam int MAX_BL = blank_cycles(2'd0, CLK_KHZ);
    localparam int CW     = $clog2(MAX_BL + 1) + 1;

    logic [NSW-1:0] flag_s;
    logic [NSW-1:0] armed;
    logic [CW-1:0]  lim;

    assign lim = CW'(blank_cycles(blank_sel, CLK_KHZ));

    dsm_sync #(.W(NSW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (vds_hi),
        .q   (flag_s)
    );

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        dsm_blank_timer #(.CW(CW)) u_tmr (
            .clk   (clk),
            .rst   (rst),
            .live  (gate_live[i]),
            .lim   (lim),
            .armed (armed[i])
        );
    end

    dsm_fault_ctl #(.NSW(NSW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .armed   (armed),
        .flag_s  (flag_s),
        .chk_en  (chk_en),
        .shut_en (shut_en),
        .dis_ack (dis_ack),
        .err     (vds_err),
        .evt     (err_evt),
        .off     (bridge_off)
    );
endmodule

// File: rtl/dsm_monitor_chk.sv
module dsm_monitor_chk #(
    parameter int NSW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [NSW-1:0] gate_live,
    input logic           chk_en,
    input logic           shut_en,
    input logic           dis_ack,
    input logic [NSW-1:0] vds_err,
    input logic           err_evt,
    input logic           bridge_off
);
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> (vds_err == '0 && !err_evt)); // R5

    AST_ERR_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
        (vds_err & ~$past(gate_live)) == '0); // R3

    AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        err_evt |-> ((vds_err & ~$past(vds_err)) != '0)); // R8

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bridge_off && !dis_ack) |=> bridge_off); // R7

    AST_OFF_NEEDS_SHUT: assert property (@(posedge clk) disable iff (rst)
        $rose(bridge_off) |-> $past(chk_en && shut_en)); // R6
endmodule

bind dsm_monitor dsm_monitor_chk #(.NSW(NSW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_live  (gate_live),
    .chk_en     (chk_en),
    .shut_en    (shut_en),
    .dis_ack    (dis_ack),
    .vds_err    (vds_err),
    .err_evt    (err_evt),
    .bridge_off (bridge_off)
);

// File: tb/dsm_monitor_test.sv
module dsm_monitor_test;
    localparam int PERIOD  = 10;
    localparam int NSW     = 6;
    localparam int CLK_KHZ = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NSW-1:0] gate_live = '0;
    logic [NSW-1:0] vds_hi = '0;
    logic [1:0]     blank_sel = 2'd3;
    logic           chk_en = 1'b0;
    logic           shut_en = 1'b0;
    logic           dis_ack = 1'b0;
    logic [NSW-1:0] vds_err;
    logic           err_evt;
    logic           bridge_off;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dsm_monitor #(.NSW(NSW), .CLK_KHZ(CLK_KHZ)) uut (
        .clk (clk), .rst (rst), .gate_live (gate_live), .vds_hi (vds_hi),
        .blank_sel (blank_sel), .chk_en (chk_en), .shut_en (shut_en),
        .dis_ack (dis_ack), .vds_err (vds_err), .err_evt (err_evt),
        .bridge_off (bridge_off)
    );

    function automatic int blank_len(input logic [1:0] c);
        int t [4] = '{6800, 3400, 1700, 800};
        return (t[c] * CLK_KHZ) / 1000000;
    endfunction

    // behavioural reference
    int             m_cnt [NSW];
    logic [NSW-1:0] m_s1, m_s2, m_err;
    logic           m_evt, m_off;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_s1 = '0; m_s2 = '0; m_err = '0; m_evt = 0; m_off = 0;
        end else begin
            logic [NSW-1:0] ne;
            int lim;
            lim = blank_len(blank_sel);
            ne = '0;
            for (int i = 0; i < NSW; i++) begin
                if (gate_live[i] && m_cnt[i] >= lim && m_s2[i] && chk_en) ne[i] = 1'b1;
                if (!gate_live[i]) m_cnt[i] = 0;
                else if (m_cnt[i] < lim) m_cnt[i] = m_cnt[i] + 1;
            end
            m_evt = |(ne & ~m_err);
            m_off = (chk_en && shut_en && (|ne)) || (m_off && !dis_ack);
            m_err = ne;
            m_s2  = m_s1;
            m_s1  = vds_hi;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 vds_err vs model", int'(vds_err), int'(m_err));
            check("R8 err_evt vs model", int'(err_evt), int'(m_evt));
            check("R7 bridge_off vs model", int'(bridge_off), int'(m_off));
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // raise gate of switch s and count cycles until its error shows
    task automatic time_err(input int s, output int n);
        gate_live[s] = 1'b1;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            n++;
            if (vds_err[s]) break;
        end
    endtask

    initial begin
        int n;
        logic [15:0] lf;
        cyc(3);
        check("R1 reset vds_err", int'(vds_err), 0);
        check("R1 reset bridge_off", int'(bridge_off), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'({vds_err, err_evt, bridge_off}), 0);

        // R2 / R6: each blanking code, report-only
        chk_en = 1'b1; shut_en = 1'b0;
        for (int c = 0; c < 4; c++) begin
            blank_sel = c[1:0];
            vds_hi[0] = 1'b1;
            cyc(3);
            time_err(0, n);
            check("R2 blanking length", n, blank_len(c[1:0]) + 1);
            check("R6 no bridge_off when report-only", int'(bridge_off), 0);
            gate_live[0] = 1'b0;
            vds_hi[0] = 1'b0;
            cyc(3);
        end

        // R4: gate off mid-blank restarts the interval
        blank_sel = 2'd3;
        vds_hi[0] = 1'b1;
        gate_live[0] = 1'b1;
        cyc(10);
        gate_live[0] = 1'b0;
        cyc(1);
        time_err(0, n);
        check("R4 restart after gate off", n, blank_len(2'd3) + 1);
        gate_live[0] = 1'b0; vds_hi[0] = 1'b0;
        cyc(3);

        // R9: only one switch flagged
        gate_live = '1;
        vds_hi = 6'b001000;
        cyc(40);
        check("R9 single channel", int'(vds_err), 8);
        gate_live = '0; vds_hi = '0;
        cyc(3);

        // R5: checking disabled
        chk_en = 1'b0; shut_en = 1'b1;
        gate_live = '1; vds_hi = '1;
        cyc(40);
        check("R5 no errors when disabled", int'(vds_err), 0);
        check("R5 no bridge_off when disabled", int'(bridge_off), 0);
        gate_live = '0; vds_hi = '0;
        cyc(3);

        // R7: shut mode latch and acknowledge
        chk_en = 1'b1;
        vds_hi[2] = 1'b1;
        cyc(3);
        time_err(2, n);
        check("R7 bridge_off with error", int'(bridge_off), 1);
        gate_live = '0; vds_hi = '0;
        cyc(10);
        check("R7 bridge_off held", int'(bridge_off), 1);
        dis_ack = 1'b1;
        @(negedge clk);
        dis_ack = 1'b0;
        check("R7 bridge_off cleared by ack", int'(bridge_off), 0);
        cyc(2);

        // mixed stimulus against the model
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0) gate_live[lf[6:4] % NSW] = ~gate_live[lf[6:4] % NSW];
            if (lf[1]) vds_hi = lf[12:7];
            dis_ack = (lf[9:6] == 4'd0);
            if (lf[15:11] == 5'd0) chk_en = ~chk_en;
            if (lf[15:11] == 5'd1) shut_en = ~shut_en;
            if (lf[15:10] == 6'd3) blank_sel = lf[1:0];
        end
        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule